// File: doc/BRIEF.md
# Digit-Serial GF(2^m) Multiplier

This block multiplies two elements of a binary extension field GF(2^m). Elements are held in a polynomial basis, and the field is defined by the modulus F(x) = x^M + P(x). Here P(x) is a sparse low-order polynomial given as a parameter. The default field is M = 81 with F(x) = x^81 + x^4 + 1. Coefficient arithmetic is modulo 2, so every addition is an XOR.

The multiplier operand B is cut into NDIG = ceil(M/DIG) digits of DIG bits, and the block handles one digit per clock. Digits are taken most significant first, in Horner order. On each step the accumulator is multiplied by x^DIG, the current digit times A is added, and the overflow above bit M-1 is folded back into the field in one pass through P(x). That single pass is enough only when M minus the degree of P(x) is at least DIG. The width DIG is a parameter restricted to 2, 4, 8 or 16, so latency is traded against area through one number.

A controller issues a one-cycle `go` pulse while the unit is idle and waits for the one-cycle `done` pulse. While `done` is high it may issue the next `go`.

Top module: `gf2m_digit_mult`

## Requirements
- R1: When `done` is high, `prod` equals op_a·op_b mod (x^M + POLY_LOW), with bit i of each vector being the coefficient of x^i; default M = 81, POLY_LOW = x^4 + 1.
- R2: The operand B is split into ceil(M/DIG) digits, processed most significant first; when M is not a multiple of DIG the upper digit is zero-padded, so an all-ones B still yields the exact field product.
- R3: `done` goes high exactly ceil(M/DIG) clock edges after the edge that accepts `go` (11 edges for M = 81, DIG = 8).
- R4: `go` is accepted only when `busy` is low; `busy` is high on the following cycle, and the operands are captured at the accepting edge, so later changes of op_a/op_b do not affect the result.
- R5: `done` is high for exactly one cycle per accepted operation.
- R6: `busy` is low in the cycle in which `done` is high, and a `go` in that cycle starts a new operation.
- R7: A `go` that arrives while `busy` is high is ignored: the running product, its timing and its count of `done` pulses are unchanged.
- R8: `prod` holds its value in every cycle in which `done` is low.
- R9: While `rst` is high and after it, until the first accepted `go`, `busy` and `done` are 0 and `prod` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request, sampled when idle |
| op_a | input | M | Multiplicand A |
| op_b | input | M | Multiplier B, consumed DIG bits per cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: `prod` is valid |
| prod | output | M | Product A·B mod F(x), held between pulses |

## Verification
The bench builds the block with its defaults, M = 81, DIG = 8 and modulus x^81 + x^4 + 1. With these values there are eleven digits, and the top digit carries seven padding zeros, so the padding path and the fold of the eight overflow bits through the trinomial are both exercised. Operands of x^80, all ones and random values force several consecutive reductions. Each result is compared with a bit-serial shift-and-add product computed in the bench. The latency of eleven edges lets the bench issue ignored starts mid-run and back-to-back starts in the `done` cycle.

// File: rtl/gfdm_pkg.sv
package gfdm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gfdm_state_t;

    function automatic int gfdm_ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic bit gfdm_digit_legal(input int dig);
        return (dig == 2) || (dig == 4) || (dig == 8) || (dig == 16);
    endfunction

endpackage

// File: rtl/gfdm_ctrl.sv
module gfdm_ctrl
    import gfdm_pkg::*;
#(
    parameter int NDIG = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic done,
    output logic load,
    output logic step,
    output logic last
);
    localparam int CW = $clog2(NDIG + 1);

    gfdm_state_t     state_q;
    logic [CW-1:0]   cnt_q;

    assign busy = (state_q == ST_RUN);
    assign load = (state_q == ST_IDLE) && go;
    assign step = (state_q == ST_RUN);
    assign last = step && (cnt_q == CW'(NDIG - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gfdm_oper_reg.sv
module gfdm_oper_reg #(
    parameter int M    = 81,
    parameter int DIG  = 8,
    parameter int NDIG = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [M-1:0]   op_a,
    input  logic [M-1:0]   op_b,
    output logic [M-1:0]   a_q,
    output logic [DIG-1:0] digit
);
    localparam int BW = NDIG * DIG;

    logic [BW-1:0] bsh_q;

    assign digit = bsh_q[BW-1 -: DIG];

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            bsh_q <= '0;
        end else if (load) begin
            a_q   <= op_a;
            bsh_q <= BW'(op_b);
        end else if (step) begin
            bsh_q <= bsh_q << DIG;
        end
    end
endmodule

// File: rtl/gfdm_step.sv
module gfdm_step #(
    parameter int           M        = 81,
    parameter int           DIG      = 8,
    parameter logic [M-1:0] POLY_LOW = M'(17)
) (
    input  logic [M-1:0]   acc,
    input  logic [M-1:0]   a,
    input  logic [DIG-1:0] digit,
    output logic [M-1:0]   acc_next
);
    localparam int WW = M + DIG;

    logic [WW-1:0]  wide;
    logic [DIG-1:0] hi;
    logic [M-1:0]   fold;

    always_comb begin
        wide = {acc, {DIG{1'b0}}};
        for (int j = 0; j < DIG; j++) begin
            if (digit[j]) begin
                wide = wide ^ (WW'(a) << j);
            end
        end
    end

    assign hi = wide[WW-1 -: DIG];

    always_comb begin
        fold = '0;
        for (int j = 0; j < DIG; j++) begin
            if (hi[j]) begin
                fold = fold ^ (POLY_LOW << j);
            end
        end
    end

    assign acc_next = wide[M-1:0] ^ fold;
endmodule

// File: rtl/gf2m_digit_mult.sv
module gf2m_digit_mult
    import gfdm_pkg::*;
#(
    parameter int           M        = 81,
    parameter int           DIG      = 8,
    parameter logic [M-1:0] POLY_LOW = M'(17),
    localparam int          NDIG     = gfdm_ceil_div(M, DIG)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [M-1:0] op_a,
    input  logic [M-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [M-1:0] prod
);
    function automatic int poly_deg(input logic [M-1:0] p);
        int d;
        d = 0;
        for (int i = 0; i < M; i++) begin
            if (p[i]) d = i;
        end
        return d;
    endfunction

    localparam int PDEG = poly_deg(POLY_LOW);

    generate
        if (!gfdm_digit_legal(DIG) || (M - PDEG < DIG)) begin : g_bad_cfg
            $error("gf2m_digit_mult: digit width or modulus not usable");
        end
    endgenerate

    logic           load;
    logic           step;
    logic           last;
    logic [M-1:0]   a_q;
    logic [DIG-1:0] digit;
    logic [M-1:0]   acc_q;
    logic [M-1:0]   acc_next;

    gfdm_ctrl #(.NDIG(NDIG)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .busy (busy),
        .done (done),
        .load (load),
        .step (step),
        .last (last)
    );

    gfdm_oper_reg #(.M(M), .DIG(DIG), .NDIG(NDIG)) u_oper (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .step  (step),
        .op_a  (op_a),
        .op_b  (op_b),
        .a_q   (a_q),
        .digit (digit)
    );

    gfdm_step #(.M(M), .DIG(DIG), .POLY_LOW(POLY_LOW)) u_step (
        .acc      (acc_q),
        .a        (a_q),
        .digit    (digit),
        .acc_next (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            prod  <= '0;
        end else begin
            if (load) begin
                acc_q <= '0;
            end else if (step) begin
                acc_q <= acc_next;
            end
            if (last) begin
                prod <= acc_next;
            end
        end
    end
endmodule

// File: rtl/gfdm_checker.sv
module gfdm_checker #(
    parameter int M    = 81,
    parameter int NDIG = 11
) (
    input logic         clk,
    input logic         rst,
    input logic         go,
    input logic         busy,
    input logic         done,
    input logic [M-1:0] prod
);
    logic [15:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else if (go && !busy) begin
            lat_q <= '0;
        end else if (busy) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_q == 16'(NDIG)));

    a_r4_accept: assert property (@(posedge clk) disable iff (rst)
        (go && !busy) |=> busy);

    a_r5_one_cycle_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_idle_on_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r7_busy_ignores_go: assert property (@(posedge clk) disable iff (rst)
        (busy && go && !done) |=> (busy || done));

    a_r8_prod_held: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(prod));

    a_r9_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done));
endmodule

bind gf2m_digit_mult gfdm_checker #(.M(M), .NDIG(NDIG)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .go   (go),
    .busy (busy),
    .done (done),
    .prod (prod)
);

// File: tb/gf2m_digit_mult_tb.sv
module gf2m_digit_mult_tb;
    localparam int           M    = 81;
    localparam int           DIG  = 8;
    localparam int           NDIG = (M + DIG - 1) / DIG;
    localparam logic [M-1:0] POLY = M'(17);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go = 1'b0;
    logic [M-1:0] op_a = '0;
    logic [M-1:0] op_b = '0;
    logic         busy;
    logic         done;
    logic [M-1:0] prod;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit finished = 1'b0;

    logic [M-1:0] exp_q[$];
    int           due_q[$];
    string        tag_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gf2m_digit_mult #(.M(M), .DIG(DIG), .POLY_LOW(POLY)) u_dut (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .op_a (op_a),
        .op_b (op_b),
        .busy (busy),
        .done (done),
        .prod (prod)
    );

    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r;
        logic         top;
        r = '0;
        for (int i = M - 1; i >= 0; i--) begin
            top = r[M-1];
            r   = r << 1;
            if (top) r = r ^ POLY;
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [M-1:0] rnd();
        return M'({$urandom(), $urandom(), $urandom()});
    endfunction

    task automatic chk(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // driver: called at a falling edge; waits for idle, pulses go, pushes expectation
    task automatic drive(input logic [M-1:0] a, input logic [M-1:0] b, input string tag);
        while (busy) @(negedge clk);
        op_a = a;
        op_b = b;
        go   = 1'b1;
        exp_q.push_back(ref_mul(a, b));
        due_q.push_back(cyc + 1 + NDIG);
        tag_q.push_back(tag);
        @(negedge clk);
        go   = 1'b0;
        op_a = rnd();   // R4: operands after capture must not matter
        op_b = rnd();
    endtask

    // monitor / scoreboard
    logic [M-1:0] held;
    bit           hold_ok = 1'b1;
    bit           prev_done = 1'b0;

    always @(negedge clk) begin
        logic [M-1:0] e;
        int           d;
        string        t;
        if (!rst) begin
            if (prev_done) chk(!done, "R5", M'(done), M'(0));
            if (!done && prod !== held) hold_ok = 1'b0;
            if (done) begin
                chk(hold_ok, "R8", prod, held);
                hold_ok = 1'b1;
                chk(!busy, "R6", M'(busy), M'(0));
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 (unexpected done)", prod, '0);
                end else begin
                    e = exp_q.pop_front();
                    d = due_q.pop_front();
                    t = tag_q.pop_front();
                    chk(prod === e, t, prod, e);
                    chk(cyc == d, "R3", M'(cyc), M'(d));
                end
            end
            held      = prod;
            prev_done = done;
        end
    end

    initial begin
        logic [M-1:0] ones;
        ones = '1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && prod == '0, "R9", prod, '0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && prod == '0, "R9", prod, '0);
        held = prod;

        drive('0, rnd(), "R1");
        drive(rnd(), '0, "R1");
        drive(M'(1), rnd(), "R1");
        drive(rnd(), M'(1), "R1");
        drive(ones, ones, "R2");
        drive(rnd(), ones, "R2");
        drive(M'(1) << (M - 1), M'(1) << (M - 1), "R1");
        drive(ones, M'(1) << (M - 1), "R1");

        // R4: busy high one cycle after acceptance
        while (busy) @(negedge clk);
        op_a = rnd();
        op_b = rnd();
        go   = 1'b1;
        exp_q.push_back(ref_mul(op_a, op_b));
        due_q.push_back(cyc + 1 + NDIG);
        tag_q.push_back("R1");
        @(negedge clk);
        go = 1'b0;
        chk(busy, "R4", M'(busy), M'(1));

        // R7: go pulses while busy must be ignored
        op_a = ones;
        op_b = ones;
        go   = 1'b1;
        repeat (3) @(negedge clk);
        go = 1'b0;
        chk(busy, "R7", M'(busy), M'(1));
        while (busy) @(negedge clk);
        repeat (NDIG + 4) @(negedge clk);
        chk(exp_q.size() == 0 && !busy, "R7", M'(exp_q.size()), '0);

        // random back-to-back traffic (R6: start in the done cycle)
        for (int k = 0; k < 40; k++) begin
            drive(rnd(), rnd(), "R1");
        end

        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5", M'(exp_q.size()), '0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule